// File: doc/BRIEF.md
# Calendar Alarm Match Comparator

This block watches a running set of time-of-day and calendar bytes and reports when any of several programmed alarms comes true. Each alarm owns one configuration byte per calendar field: seconds, minutes, hours, day of month, month and day of week. Each byte holds a value in the same BCD form the clock uses, plus a top bit that enables that field for comparison. Any mix of fields can be enabled, so one alarm can fire once a minute, once a day or on one exact date and time. The year has no alarm byte and never affects a match.

A host programs the alarm bytes through a simple write port. The clock keeper outside the block presents the current field bytes in parallel and pulses a one-second tick. The block checks the alarms only on tick cycles. On the tick where an alarm's comparison turns true, it emits a one-cycle match strobe and sets a sticky status flag for that alarm. The flag stays set until the host clears it with a write.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset every match strobe and every status flag is 0, and every alarm byte is 0, so every field is disabled. A tick with all clock bytes at zero therefore produces no strobe.
- R2: The write address is {alarm index, 3-bit slot}. Slot 0 is seconds, 1 minutes, 2 hours, 3 day of month, 4 month and 5 day of week. Bit 7 of an alarm byte is the field enable and bits 6:0 hold the value. Clock byte k sits at bits 8k+7:8k of `cur_time`.
- R3: An enabled field hits when the clock byte equals {0, alarm bits 6:0}, so a clock byte with bit 7 set never hits. A disabled field is ignored whatever its value.
- R4: Any subset of one to six fields may be enabled. The alarm's comparison is true when every enabled field hits.
- R5: An alarm with no field enabled never produces a strobe or sets its flag.
- R6: A strobe is one clock cycle wide and rises in the cycle after a tick on which the comparison is true and was false on the previous tick (false is assumed before the first tick). If the comparison stays true on consecutive ticks, no further strobe is issued. A new strobe follows only after a tick on which the comparison was false.
- R7: The comparison is evaluated only in cycles where `tick` is 1. Clock bytes that change with `tick` at 0 cause no strobe.
- R8: An alarm's status flag is set in the same cycle as its strobe and stays set across later ticks.
- R9: A write to slot 7 of an alarm with data bit 0 at 1 clears that alarm's flag. With data bit 0 at 0 it has no effect, and it never touches another alarm's flag.
- R10: When a clear write and a flag-setting tick fall in the same cycle, the flag ends up set (default `SET_WINS` = 1).
- R11: The alarms are independent. Each compares its own bytes against the same clock bytes and drives only its own strobe and flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W (4) | {alarm index, slot} |
| wr_data | input | BYTE_W (8) | Alarm byte, or clear request in bit 0 for slot 7 |
| tick | input | 1 | One-second tick, one cycle wide |
| cur_time | input | NUM_FIELDS*BYTE_W (48) | Current clock field bytes |
| match_pulse | output | NUM_ALARMS (2) | One-cycle match strobe per alarm |
| match_flag | output | NUM_ALARMS (2) | Sticky match status per alarm |

## Verification
A stored enable or value byte that goes wrong shows up only on the next tick whose clock bytes test that field. It appears as a strobe that is missing, or one that appears where none is expected. The bench therefore sweeps every enable mask against clock patterns that break chosen fields. A stale previous-tick state shows as a repeated or lost strobe one tick later. A flag error persists on `match_flag` until the next clear, so it is visible in the very next sampled cycle.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
   localparam int unsigned SLOT_W     = 3;
   localparam int unsigned CLR_SLOT   = 7;
   localparam int unsigned DEF_FIELDS = 6;
   localparam int unsigned DEF_BYTE_W = 8;
   localparam int unsigned DEF_ALARMS = 2;
endpackage

// File: rtl/cal_field_cmp.sv
module cal_field_cmp #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] cfg_byte,
   input  logic [BYTE_W-1:0] cur_byte,
   output logic              fld_en,
   output logic              fld_hit
);
   localparam int unsigned VAL_W = BYTE_W - 1;

   logic [BYTE_W-1:0] want;

   always_comb begin
      fld_en  = cfg_byte[BYTE_W-1];
      want    = {1'b0, cfg_byte[VAL_W-1:0]};
      fld_hit = !fld_en || (want == cur_byte);
   end
endmodule

// File: rtl/cal_alarm_bank.sv
module cal_alarm_bank
   import cal_alarm_pkg::*;
#(
   parameter int unsigned NUM_FIELDS = DEF_FIELDS,
   parameter int unsigned BYTE_W     = DEF_BYTE_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sel_wr,
   input  logic [SLOT_W-1:0]            wr_slot,
   input  logic [BYTE_W-1:0]            wr_data,
   output logic [NUM_FIELDS*BYTE_W-1:0] cfg,
   output logic                         clr_req
);
   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
      logic [BYTE_W-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            byte_q <= '0;
         else if (sel_wr && wr_slot == SLOT_W'(f))
            byte_q <= wr_data;
      end
      assign cfg[f*BYTE_W +: BYTE_W] = byte_q;
   end

   assign clr_req = sel_wr && (wr_slot == SLOT_W'(CLR_SLOT)) && wr_data[0];
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match #(
   parameter int unsigned NUM_FIELDS = 6,
   parameter int unsigned BYTE_W     = 8,
   parameter bit          SET_WINS   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick,
   input  logic [NUM_FIELDS*BYTE_W-1:0] cfg,
   input  logic [NUM_FIELDS*BYTE_W-1:0] cur_time,
   input  logic                         clr_req,
   output logic                         pulse,
   output logic                         flag
);
   logic [NUM_FIELDS-1:0] en_v;
   logic [NUM_FIELDS-1:0] hit_v;
   logic                  any_en;
   logic                  cmp_now;
   logic                  prev_q;
   logic                  set_now;
   logic                  flag_d;

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
      cal_field_cmp #(.BYTE_W(BYTE_W)) i_cmp (
         .cfg_byte (cfg[f*BYTE_W +: BYTE_W]),
         .cur_byte (cur_time[f*BYTE_W +: BYTE_W]),
         .fld_en   (en_v[f]),
         .fld_hit  (hit_v[f])
      );
   end

   always_comb begin
      any_en  = |en_v;
      cmp_now = any_en && (&hit_v);
      set_now = tick && cmp_now && !prev_q;
   end

   if (SET_WINS) begin : g_set_wins
      assign flag_d = set_now || (flag && !clr_req);
   end else begin : g_clr_wins
      assign flag_d = (set_now || flag) && !clr_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pulse  <= 1'b0;
         flag   <= 1'b0;
      end else begin
         if (tick)
            prev_q <= cmp_now;
         pulse <= set_now;
         flag  <= flag_d;
      end
   end

   AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse); // R6
   AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> $past(tick)); // R7
   AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> $past(any_en)); // R5
   AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> (flag || $past(clr_req))); // R8
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(clr_req)); // R9
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
   import cal_alarm_pkg::*;
#(
   parameter int unsigned NUM_ALARMS = DEF_ALARMS,
   parameter int unsigned NUM_FIELDS = DEF_FIELDS,
   parameter int unsigned BYTE_W     = DEF_BYTE_W,
   parameter bit          SET_WINS   = 1'b1,
   localparam int unsigned AIDX_W    = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1,
   localparam int unsigned ADDR_W    = AIDX_W + SLOT_W,
   localparam int unsigned TIME_W    = NUM_FIELDS * BYTE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [BYTE_W-1:0]     wr_data,
   input  logic                  tick,
   input  logic [TIME_W-1:0]     cur_time,
   output logic [NUM_ALARMS-1:0] match_pulse,
   output logic [NUM_ALARMS-1:0] match_flag
);
   if (NUM_ALARMS < 1) begin : g_bad_alarms
      $error("cal_alarm_cmp: NUM_ALARMS must be at least 1");
   end
   if (NUM_FIELDS < 1 || NUM_FIELDS > CLR_SLOT) begin : g_bad_fields
      $error("cal_alarm_cmp: NUM_FIELDS must lie in 1..7");
   end
   if (BYTE_W < 2) begin : g_bad_width
      $error("cal_alarm_cmp: BYTE_W must be at least 2");
   end

   logic [AIDX_W-1:0] wr_idx;
   logic [SLOT_W-1:0] wr_slot;

   assign wr_idx  = wr_addr[ADDR_W-1:SLOT_W];
   assign wr_slot = wr_addr[SLOT_W-1:0];

   for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alm
      logic              sel_wr;
      logic [TIME_W-1:0] cfg;
      logic              clr_req;

      assign sel_wr = wr_en && (wr_idx == AIDX_W'(a));

      cal_alarm_bank #(.NUM_FIELDS(NUM_FIELDS), .BYTE_W(BYTE_W)) i_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel_wr  (sel_wr),
         .wr_slot (wr_slot),
         .wr_data (wr_data),
         .cfg     (cfg),
         .clr_req (clr_req)
      );

      cal_alarm_match #(.NUM_FIELDS(NUM_FIELDS), .BYTE_W(BYTE_W),
                        .SET_WINS(SET_WINS)) i_match (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick),
         .cfg      (cfg),
         .cur_time (cur_time),
         .clr_req  (clr_req),
         .pulse    (match_pulse[a]),
         .flag     (match_flag[a])
      );
   end

   AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> (match_pulse == '0)); // R7
   AST_FLAG_SET_FROM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ((match_flag & ~$past(match_flag)) & ~match_pulse) == '0); // R8
endmodule

// File: tb/test_cal_alarm_cmp.sv
module test_cal_alarm_cmp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        tick = 1'b0;
   logic [47:0] cur_time = '0;
   logic [1:0]  match_pulse;
   logic [1:0]  match_flag;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cal_alarm_cmp i_cal_alarm_cmp (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tick(tick), .cur_time(cur_time),
      .match_pulse(match_pulse), .match_flag(match_flag)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int alm, input int slot, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = {alm[0], slot[2:0]}; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // tick with given clock bytes; returns at the negedge where the strobe shows
   task automatic do_tick(input logic [47:0] tv);
      @(negedge clk);
      cur_time = tv; tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   function automatic logic [7:0] tgt(input int i);
      return 8'(i * 17 + 1);
   endfunction

   function automatic logic [47:0] mk(input logic [5:0] brk);
      logic [47:0] v;
      for (int i = 0; i < 6; i++) v[i*8 +: 8] = tgt(i) + (brk[i] ? 8'd1 : 8'd0);
      return v;
   endfunction

   initial begin
      #3_000_000;
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [5:0] brk_set [4];
      brk_set[0] = 6'h00; brk_set[1] = 6'h01; brk_set[2] = 6'h2A; brk_set[3] = 6'h3F;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(match_pulse == 2'b00, "R1 pulse", match_pulse, 0);
      check(match_flag == 2'b00, "R1 flag", match_flag, 0);
      do_tick('0);
      check(match_pulse == 2'b00, "R1 disabled at reset", match_pulse, 0);

      // R2 R3 R4 R5 sweep every enable mask of alarm 0 against broken-field patterns
      for (int e = 0; e < 64; e++) begin
         for (int f = 0; f < 6; f++) wr(0, f, {e[f], tgt(f)[6:0]});
         for (int b = 0; b < 4; b++) begin
            bit exp_m;
            do_tick(mk(6'h3F));
            do_tick(mk(brk_set[b]));
            exp_m = (e != 0) && ((6'(e) & brk_set[b]) == 6'h00);
            check(match_pulse[0] == exp_m, $sformatf("R4 mask %0d brk %0d", e, b),
                  match_pulse[0], exp_m);
            if (e == 0) check(match_pulse[0] == 1'b0, "R5 no fields", match_pulse[0], 0);
            check(match_pulse[1] == 1'b0, "R11 other alarm quiet", match_pulse[1], 0);
            wr(0, 7, 8'h01);
         end
      end

      // R3 clock byte with top bit set never hits; disabled field ignored
      for (int f = 0; f < 6; f++) wr(0, f, 8'h00);
      wr(0, 0, 8'h85);
      wr(0, 1, 8'h33);
      do_tick(48'h0);
      do_tick({40'h0, 8'h85});
      check(match_pulse[0] == 1'b0, "R3 top bit mismatch", match_pulse[0], 0);
      do_tick({32'h0, 8'h77, 8'h05});
      check(match_pulse[0] == 1'b1, "R3 value hit disabled ignored", match_pulse[0], 1);

      // R6 one cycle wide, held match gives no second strobe, refire after miss
      @(negedge clk);
      check(match_pulse[0] == 1'b0, "R6 width", match_pulse[0], 0);
      do_tick({32'h0, 8'h12, 8'h05});
      check(match_pulse[0] == 1'b0, "R6 held", match_pulse[0], 0);
      do_tick({32'h0, 8'h12, 8'h06});
      check(match_pulse[0] == 1'b0, "R6 miss", match_pulse[0], 0);
      do_tick({32'h0, 8'h12, 8'h05});
      check(match_pulse[0] == 1'b1, "R6 refire", match_pulse[0], 1);

      // R8 flag sticky across ticks
      do_tick({32'h0, 8'h12, 8'h07});
      check(match_flag[0] == 1'b1, "R8 sticky", match_flag[0], 1);

      // R9 clears
      wr(0, 7, 8'h00);
      check(match_flag[0] == 1'b1, "R9 bit0 zero no effect", match_flag[0], 1);
      wr(1, 7, 8'h01);
      check(match_flag[0] == 1'b1, "R9 other alarm clear", match_flag[0], 1);
      wr(0, 7, 8'h01);
      check(match_flag[0] == 1'b0, "R9 clear", match_flag[0], 0);

      // R7 no evaluation without tick
      @(negedge clk);
      cur_time = {40'h0, 8'h05};
      repeat (4) @(negedge clk);
      check(match_pulse[0] == 1'b0, "R7 no tick", match_pulse[0], 0);
      check(match_flag[0] == 1'b0, "R7 no tick flag", match_flag[0], 0);
      do_tick({40'h0, 8'h05});
      check(match_pulse[0] == 1'b1, "R7 tick fires", match_pulse[0], 1);

      // R10 set wins over a same-cycle clear
      wr(0, 7, 8'h01);
      do_tick(48'h0);
      @(negedge clk);
      cur_time = {40'h0, 8'h05}; tick = 1'b1;
      wr_en = 1'b1; wr_addr = 4'b0111; wr_data = 8'h01;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
      check(match_flag[0] == 1'b1, "R10 set wins", match_flag[0], 1);

      // R11 alarm 1 on month only, independent of alarm 0
      wr(0, 7, 8'h01);
      wr(1, 4, 8'h92);
      do_tick(48'h0);
      do_tick({8'h0, 8'h12, 24'h0, 8'h09});
      check(match_pulse == 2'b10, "R11 alarm1 alone", match_pulse, 2);
      check(match_flag == 2'b10, "R11 flags", match_flag, 2);
      wr(1, 7, 8'h01);
      check(match_flag == 2'b00, "R11 clear alarm1", match_flag, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule